// File: doc/BRIEF.md
# Boot-Strap and External Interrupt Pin Block

This block serves four shared, active-low external pins. Every pin is first brought into the core clock domain through a two-flop synchronizer. While hardware reset is held, the synchronized levels are sampled continuously. The value from the last clock edge with reset low becomes a 4-bit start-up mode, and that mode stays fixed until the next reset.

Once reset is released, each pin acts as an active-low interrupt request. Each request can be masked, and each can detect either a low level or a falling edge. In edge mode a pending flag is held until the interrupt controller acknowledges it. Any pin can instead be configured as a general-purpose I/O bit that reads as an input, drives as an output, or is disconnected.

The block also drives a wake request. It is raised while the core is in stop standby and the designated wake pin is low. The configuration arrives as inputs from registers held elsewhere.

Top module: `strap_irq_pins`

## Requirements
- R1: A pin change reaches the block's logic only after two clock edges. A level that is present before edge k is first visible at the outputs after edge k+1.
- R2: `boot_mode` takes the synchronized pin levels at every clock edge where `rst_n` is 0. At edges where `rst_n` is 1 it holds its value, so it keeps the levels from the last edge of reset.
- R3: While `rst_n` is 0, `irq_req`, `pin_oe`, `pin_out` and `wake` are all 0, and every edge-pending flag is cleared.
- R4: With `cfg_edge[i]`=1 and `cfg_gpio[i]`=0, a 1-to-0 transition of the synchronized pin sets pending bit i. The bit stays set until an edge where `irq_ack[i]`=1 and no new falling transition occurs. A new transition in the same cycle as an acknowledge wins.
- R5: With `cfg_edge[i]`=0 and `cfg_gpio[i]`=0, the request is level-sensitive. `irq_req[i]` equals the inverted synchronized level, gated by the enable.
- R6: With `cfg_irq_en[i]`=0, `irq_req[i]` is 0. A falling edge seen while masked in edge mode still sets pending, and `irq_req[i]` rises as soon as the pin is unmasked.
- R7: With `cfg_gpio[i]`=1 the pin raises no interrupt and its pending flag is cleared. `gpio_rdata[i]` returns the synchronized level when the 2-bit direction `cfg_dir[2i+1:2i]` is 01 (input) or 10 (output), and returns 0 for 00 or 11 (disconnected).
- R8: `pin_oe[i]` is 1 only out of reset, with `cfg_gpio[i]`=1 and direction 10. `pin_out[i]` equals `gpio_wdata[i]` when `pin_oe[i]` is 1, and is 0 otherwise.
- R9: `wake` is 1 exactly when `rst_n`=1, `stop_req`=1 and the synchronized level of pin `WAKE_PIN` (default 0) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hardware reset, active low, sampled on the clock |
| pin_in | input | N | Raw pin levels from the pads |
| pin_oe | output | N | Pad output enable per pin |
| pin_out | output | N | Pad output data per pin |
| cfg_gpio | input | N | 1: pin is general-purpose I/O; 0: interrupt |
| cfg_edge | input | N | 1: falling-edge detection; 0: low-level |
| cfg_irq_en | input | N | 1: interrupt unmasked |
| cfg_dir | input | 2N | Per-pin I/O direction: 01 input, 10 output, else disconnected |
| gpio_wdata | input | N | Output data for I/O pins |
| gpio_rdata | output | N | Synchronized input data for I/O pins |
| irq_ack | input | N | Acknowledge pulse clearing an edge-pending flag |
| irq_req | output | N | Interrupt request per pin |
| boot_mode | output | N | Start-up mode captured at reset release |
| stop_req | input | 1 | Core is in stop standby |
| wake | output | 1 | Wake request out of stop |

## Verification
An acknowledge and a fresh falling edge on the same edge-mode pin can land on the same clock edge. The outcome must be that the flag stays set. The bench provokes this with a window in which pin 0 toggles every two cycles while acknowledge pulses arrive every three cycles, so the two align repeatedly. A long stretch of random pins, acknowledges and configuration changes follows. The behavioural model in the bench applies set-over-clear, and it is compared against `irq_req` after every clock.

// File: rtl/strap_irq_pins.sv
module strap_irq_pins #(
  parameter int N        = 4,
  parameter int WAKE_PIN = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   pin_in,
  output logic [N-1:0]   pin_oe,
  output logic [N-1:0]   pin_out,
  input  logic [N-1:0]   cfg_gpio,
  input  logic [N-1:0]   cfg_edge,
  input  logic [N-1:0]   cfg_irq_en,
  input  logic [2*N-1:0] cfg_dir,
  input  logic [N-1:0]   gpio_wdata,
  output logic [N-1:0]   gpio_rdata,
  input  logic [N-1:0]   irq_ack,
  output logic [N-1:0]   irq_req,
  output logic [N-1:0]   boot_mode,
  input  logic           stop_req,
  output logic           wake
);
  localparam logic [1:0] DIR_IN  = 2'b01;
  localparam logic [1:0] DIR_OUT = 2'b10;

  logic [N-1:0] sync1, sync2, sync3, pend;
  logic [N-1:0] fall;

  always_ff @(posedge clk) begin
    sync1 <= pin_in;
    sync2 <= sync1;
    sync3 <= sync2;
  end

  assign fall = sync3 & ~sync2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      boot_mode <= sync2;
    end else begin
      pend <= ~cfg_gpio & cfg_edge & ((pend & ~irq_ack) | fall);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [1:0] dir;
    assign dir           = cfg_dir[2*i +: 2];
    assign pin_oe[i]     = rst_n & cfg_gpio[i] & (dir == DIR_OUT);
    assign pin_out[i]    = pin_oe[i] & gpio_wdata[i];
    assign gpio_rdata[i] = cfg_gpio[i] & ((dir == DIR_IN) | (dir == DIR_OUT)) & sync2[i];
    assign irq_req[i]    = rst_n & ~cfg_gpio[i] & cfg_irq_en[i] &
                           (cfg_edge[i] ? pend[i] : ~sync2[i]);
  end

  assign wake = rst_n & stop_req & ~sync2[WAKE_PIN];
endmodule

module strap_irq_pins_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   pin_oe,
  input logic [N-1:0]   pin_out,
  input logic [N-1:0]   cfg_gpio,
  input logic [N-1:0]   cfg_edge,
  input logic [N-1:0]   cfg_irq_en,
  input logic [2*N-1:0] cfg_dir,
  input logic [N-1:0]   irq_ack,
  input logic [N-1:0]   irq_req,
  input logic [N-1:0]   boot_mode,
  input logic           stop_req,
  input logic           wake
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R3: assert (irq_req == '0 && pin_oe == '0 && pin_out == '0 && !wake)
        else $error("outputs active in reset");
    end
  end

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(boot_mode));

  assert_wake_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> stop_req);

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req[i] && cfg_edge[i] && !irq_ack[i])
      |=> (irq_req[i] || !cfg_irq_en[i] || cfg_gpio[i] || !cfg_edge[i]));

    assert_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_irq_en[i] |-> !irq_req[i]);

    assert_gpio_noirq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_gpio[i] |-> !irq_req[i]);

    assert_oe_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[i] |-> (cfg_gpio[i] && cfg_dir[2*i +: 2] == 2'b10));
  end
endmodule

bind strap_irq_pins strap_irq_pins_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_oe(pin_oe), .pin_out(pin_out),
  .cfg_gpio(cfg_gpio), .cfg_edge(cfg_edge), .cfg_irq_en(cfg_irq_en),
  .cfg_dir(cfg_dir), .irq_ack(irq_ack), .irq_req(irq_req),
  .boot_mode(boot_mode), .stop_req(stop_req), .wake(wake)
);

// File: tb/tb_strap_irq_pins.sv
module tb_strap_irq_pins;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] pin_in, cfg_gpio, cfg_edge, cfg_irq_en, gpio_wdata, irq_ack;
  logic [2*N-1:0] cfg_dir;
  logic stop_req;
  logic [N-1:0] pin_oe, pin_out, gpio_rdata, irq_req, boot_mode;
  logic wake;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  strap_irq_pins #(.N(N), .WAKE_PIN(0)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .cfg_gpio(cfg_gpio), .cfg_edge(cfg_edge), .cfg_irq_en(cfg_irq_en),
    .cfg_dir(cfg_dir), .gpio_wdata(gpio_wdata), .gpio_rdata(gpio_rdata),
    .irq_ack(irq_ack), .irq_req(irq_req), .boot_mode(boot_mode),
    .stop_req(stop_req), .wake(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: history of sampled pins, pending flags, mode
  logic [N-1:0] hist[$];
  logic [N-1:0] m_pend = '0;
  logic [N-1:0] m_mode = '0;
  int ncyc = 0;

  initial begin
    for (int k = 0; k < 3; k++) hist.push_back('1);
  end

  always @(posedge clk) begin
    logic [N-1:0] old_sync, older_sync;
    old_sync   = hist[hist.size()-2];
    older_sync = hist[hist.size()-3];
    for (int i = 0; i < N; i++) begin
      if (!rst_n || cfg_gpio[i] || !cfg_edge[i]) m_pend[i] = 1'b0;
      else if (older_sync[i] && !old_sync[i])   m_pend[i] = 1'b1;
      else if (irq_ack[i])                      m_pend[i] = 1'b0;
    end
    if (!rst_n) m_mode = old_sync;
    hist.push_back(pin_in);
    void'(hist.pop_front());
    ncyc++;
  end

  always @(negedge clk) begin
    if (ncyc >= 5 && !done) begin
      logic [N-1:0] s, e_irq, e_rd, e_oe, e_out;
      logic e_wake;
      s = hist[hist.size()-2];
      for (int i = 0; i < N; i++) begin
        logic [1:0] d;
        d = cfg_dir[2*i +: 2];
        e_irq[i] = rst_n && !cfg_gpio[i] && cfg_irq_en[i] && (cfg_edge[i] ? m_pend[i] : !s[i]);
        e_rd[i]  = cfg_gpio[i] && (d == 2'b01 || d == 2'b10) && s[i];
        e_oe[i]  = rst_n && cfg_gpio[i] && d == 2'b10;
        e_out[i] = e_oe[i] && gpio_wdata[i];
      end
      e_wake = rst_n && stop_req && !s[0];
      if (rst_n) begin
        chk("R2 boot_mode", boot_mode, m_mode);
        chk("R4/R5/R6/R7 irq_req", irq_req, e_irq);
        chk("R8 pin_oe", pin_oe, e_oe);
        chk("R8 pin_out", pin_out, e_out);
        chk("R9 wake", wake, e_wake);
      end else begin
        chk("R3 irq_req", irq_req, e_irq);
        chk("R3 pin_oe", pin_oe, e_oe);
        chk("R3 wake", wake, e_wake);
      end
      chk("R7 gpio_rdata", gpio_rdata, e_rd);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #3;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pin_in = 4'b0110; cfg_gpio = '0; cfg_edge = '0; cfg_irq_en = '1;
    cfg_dir = '0; gpio_wdata = '1; irq_ack = '0; stop_req = 1;
    step(6);
    @(negedge clk);
    chk("R3 reset irq", irq_req, '0);
    chk("R3 reset wake", wake, 1'b0);
    step(1);
    rst_n = 1;
    @(negedge clk);
    chk("R2 mode captured", boot_mode, 4'b0110);
    stop_req = 0;
    pin_in = 4'b1111;
    step(5);
    chk("R2 mode held", boot_mode, 4'b0110);

    // R1 latency on level-mode pin 1
    cfg_edge = '0; cfg_irq_en = 4'b0010;
    step(3);
    pin_in[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 one edge not yet visible", irq_req[1], 1'b0);
    @(negedge clk);
    chk("R1 visible after two edges", irq_req[1], 1'b1);
    step(1);
    pin_in[1] = 1'b1;
    step(4);
    chk("R5 level released", irq_req[1], 1'b0);

    // R4 edge mode sticky then acknowledged
    cfg_edge = 4'b0001; cfg_irq_en = 4'b0001;
    pin_in[0] = 0; step(3); pin_in[0] = 1; step(6);
    chk("R4 sticky after pin high", irq_req[0], 1'b1);
    irq_ack = 4'b0001; step(1); irq_ack = '0; step(1);
    chk("R4 cleared by ack", irq_req[0], 1'b0);

    // R4 ack colliding with new falls
    for (int k = 0; k < 30; k++) begin
      pin_in[0] = (k % 4) < 2;
      irq_ack[0] = (k % 3) == 0;
      step(1);
    end
    irq_ack = '0; pin_in = '1; step(4);

    // R6 masked edge seen on unmask
    cfg_edge = 4'b0100; cfg_irq_en = 4'b0000;
    pin_in[2] = 0; step(3); pin_in[2] = 1; step(4);
    chk("R6 masked silent", irq_req[2], 1'b0);
    cfg_irq_en = 4'b0100; step(1);
    chk("R6 pending after unmask", irq_req[2], 1'b1);
    irq_ack = 4'b0100; step(1); irq_ack = '0; step(1);

    // R7/R8 GPIO directions
    cfg_gpio = 4'b1111; cfg_irq_en = '1; cfg_dir = 8'b11_00_10_01;
    gpio_wdata = 4'b0110; pin_in = 4'b0101; step(4);
    chk("R7 rdata per direction", gpio_rdata, 4'b0001);
    chk("R7 no irq in gpio", irq_req, 4'b0000);
    chk("R8 oe only on output", pin_oe, 4'b0010);
    chk("R8 out data", pin_out, 4'b0010);
    pin_in = 4'b1111; step(4);
    chk("R7 rdata high", gpio_rdata, 4'b0011);

    // R9 wake
    cfg_gpio = '0; cfg_dir = '0; stop_req = 1;
    pin_in[0] = 0; step(3);
    chk("R9 wake raised", wake, 1'b1);
    pin_in[0] = 1; step(3);
    chk("R9 wake dropped", wake, 1'b0);
    stop_req = 0;

    // random stretch judged by the model
    for (int k = 0; k < 3000; k++) begin
      pin_in = $urandom; irq_ack = $urandom; stop_req = $urandom;
      gpio_wdata = $urandom;
      if (k % 37 == 0) begin
        cfg_gpio = $urandom; cfg_edge = $urandom; cfg_irq_en = $urandom; cfg_dir = $urandom;
      end
      step(1);
    end

    // second reset captures a new mode
    rst_n = 0; pin_in = 4'b1001; step(4); rst_n = 1;
    @(negedge clk);
    chk("R2 new mode", boot_mode, 4'b1001);
    step(3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule